// File: doc/BRIEF.md
# Packed Word Permute Unit

This unit rearranges 16-bit words inside a 64-bit vector and moves data between that vector and a 32-bit scalar. One 2-bit operation code picks one of four functions. Extract copies one word of the source vector into the scalar result and zero-extends it. Insert writes the low half of the scalar into one word of a destination vector and leaves the other words as they were. Shuffle builds a new vector in which each output word is any chosen word of the source. Sign gather packs the top bit of every source byte into a small scalar mask.

Word selection comes from an 8-bit control byte. Extract and insert read only its two lowest bits. Shuffle splits the whole byte into four 2-bit fields, one per output word, so a single control value can reorder, duplicate or broadcast words. The datapath is combinational. A parameter can add one register stage on both results, and that stage is on by default. The unit sits beside a vector register file in an execution pipeline. Register storage and memory access are outside it.

Top module: `wpu_top`

## Requirements
- R1: `op_sel` encodes 0 = extract, 1 = insert, 2 = shuffle, 3 = sign gather. A result port that the selected operation does not produce is zero: `vec_res` for extract and sign gather, `scl_res` for insert and shuffle.
- R2: Extract puts word `ctrl[1:0]` of `vec_a` (word n is bits 16n+15..16n) into `scl_res[15:0]` and drives `scl_res[31:16]` to zero.
- R3: For extract and insert, `ctrl[7:2]` has no effect on either result.
- R4: Insert writes `scl_in[15:0]` into word `ctrl[1:0]` of `vec_dst` to form `vec_res`. The three other words equal the matching words of `vec_dst`.
- R5: Shuffle sets output word i (i = 0..3) to source word `ctrl[2i+1:2i]` of `vec_a`. For example, field value 2'b10 picks source word 2.
- R6: The shuffle control values 8'h00, 8'h55, 8'hAA and 8'hFF broadcast source word 0, 1, 2 and 3 to all four output words.
- R7: Sign gather sets `scl_res[k]` to `vec_a[8k+7]` for k = 0..7 and drives `scl_res[31:8]` to zero.
- R8: With the default output register, results appear at the clock edge after the inputs, hold between edges, and are zero while `rst_n` is low.
- R9: Insert ignores `scl_in[31:16]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_sel | input | 2 | Operation code |
| vec_a | input | 64 | Source vector for extract, shuffle and sign gather |
| vec_dst | input | 64 | Destination vector that insert modifies |
| scl_in | input | 32 | Scalar operand; insert uses the low word |
| ctrl | input | 8 | Word-select control byte |
| vec_res | output | 64 | Vector result |
| scl_res | output | 32 | Scalar result |

## Verification
Every cycle the assertions check the zero-fill rules: the idle result port is zero, and the upper scalar bits are zero for extract and gather. They also check that an insert changes at most the selected word and writes the scalar there, and that an all-ones shuffle control gives four equal words. The mapping of each shuffle field to its output word needs the bench, which runs all 256 control values and compares them with a reference model. The bench also covers the extract word order, the gather bit order, reset, one-cycle latency, and the fact that the upper control and scalar bits have no effect.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  // Operation codes; the numeric values are part of the port contract.
  typedef enum logic [1:0] {
    WP_EXTRACT  = 2'd0,
    WP_INSERT   = 2'd1,
    WP_SHUFFLE  = 2'd2,
    WP_SIGNMASK = 2'd3
  } wp_op_e;

endpackage

// File: rtl/wpu_lane_xfer.sv
// Scalar <-> vector word transfer: extract (zero-extended) and masked insert.
module wpu_lane_xfer #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int SCL_W  = 32,
  localparam int VEC_W = LANE_W * LANES,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [SCL_W-1:0] scl_in,
  input  logic [SEL_W-1:0] sel,
  output logic [SCL_W-1:0] ext_scl,
  output logic [VEC_W-1:0] ins_vec,
  output logic [LANES-1:0] ins_hit
);

  function automatic logic [LANE_W-1:0] pick_lane(
    input logic [VEC_W-1:0] v, input logic [SEL_W-1:0] s);
    logic [LANE_W-1:0] w;
    w = '0;
    for (int i = 0; i < LANES; i++)
      if (s == SEL_W'(i)) w = v[i*LANE_W +: LANE_W];
    return w;
  endfunction

  logic [LANE_W-1:0] picked;

  always_comb begin
    picked  = pick_lane(src_vec, sel);
    ext_scl = '0;
    ext_scl[LANE_W-1:0] = picked;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_ins
    assign ins_hit[g] = (sel == SEL_W'(g));
    assign ins_vec[g*LANE_W +: LANE_W] =
      ins_hit[g] ? scl_in[LANE_W-1:0] : dst_vec[g*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/wpu_shuffle.sv
// Per-lane word permutation under a packed field-per-lane control.
module wpu_shuffle #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int VEC_W  = LANE_W * LANES,
  localparam int SEL_W  = $clog2(LANES),
  localparam int CTRL_W = LANES * SEL_W
) (
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [VEC_W-1:0]  shf_vec
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0]  field;
    logic [LANE_W-1:0] word;
    assign field = ctrl[g*SEL_W +: SEL_W];
    always_comb begin
      word = '0;
      for (int i = 0; i < LANES; i++)
        if (field == SEL_W'(i)) word = src_vec[i*LANE_W +: LANE_W];
    end
    assign shf_vec[g*LANE_W +: LANE_W] = word;
  end

endmodule

// File: rtl/wpu_sign_gather.sv
// Collects the top bit of every byte into a zero-extended scalar mask.
module wpu_sign_gather #(
  parameter int VEC_W = 64,
  parameter int SCL_W = 32,
  localparam int NBYTES = VEC_W / 8
) (
  input  logic [VEC_W-1:0] src_vec,
  output logic [SCL_W-1:0] mask_scl
);

  logic [NBYTES-1:0] signs;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign signs[k] = src_vec[8*k + 7];
  end

  always_comb begin
    mask_scl = '0;
    mask_scl[NBYTES-1:0] = signs;
  end

endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 4,
  parameter int SCL_W   = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int VEC_W  = LANE_W * LANES,
  localparam int SEL_W  = $clog2(LANES),
  localparam int CTRL_W = LANES * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic [VEC_W-1:0]  vec_a,
  input  logic [VEC_W-1:0]  vec_dst,
  input  logic [SCL_W-1:0]  scl_in,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [VEC_W-1:0]  vec_res,
  output logic [SCL_W-1:0]  scl_res
);

  wp_op_e             op;
  logic [SCL_W-1:0]   ext_scl;
  logic [SCL_W-1:0]   msk_scl;
  logic [VEC_W-1:0]   ins_vec;
  logic [VEC_W-1:0]   shf_vec;
  logic [LANES-1:0]   ins_hit;
  logic [VEC_W-1:0]   nxt_vec;
  logic [SCL_W-1:0]   nxt_scl;

  assign op = wp_op_e'(op_sel);

  wpu_lane_xfer #(.LANE_W(LANE_W), .LANES(LANES), .SCL_W(SCL_W)) u_xfer (
    .src_vec (vec_a),
    .dst_vec (vec_dst),
    .scl_in  (scl_in),
    .sel     (ctrl[SEL_W-1:0]),
    .ext_scl (ext_scl),
    .ins_vec (ins_vec),
    .ins_hit (ins_hit)
  );

  wpu_shuffle #(.LANE_W(LANE_W), .LANES(LANES)) u_shuf (
    .src_vec (vec_a),
    .ctrl    (ctrl),
    .shf_vec (shf_vec)
  );

  wpu_sign_gather #(.VEC_W(VEC_W), .SCL_W(SCL_W)) u_sign (
    .src_vec  (vec_a),
    .mask_scl (msk_scl)
  );

  always_comb begin
    nxt_vec = '0;
    nxt_scl = '0;
    unique case (op)
      WP_EXTRACT:  nxt_scl = ext_scl;
      WP_INSERT:   nxt_vec = ins_vec;
      WP_SHUFFLE:  nxt_vec = shf_vec;
      WP_SIGNMASK: nxt_scl = msk_scl;
      default: ;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_res <= '0;
        scl_res <= '0;
      end else begin
        vec_res <= nxt_vec;
        scl_res <= nxt_scl;
      end
    end
  end else begin : g_comb
    assign vec_res = nxt_vec;
    assign scl_res = nxt_scl;
  end

endmodule

// File: rtl/wpu_top_chk.sv
module wpu_top_chk
  import wpu_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 4,
  parameter int SCL_W   = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int VEC_W  = LANE_W * LANES,
  localparam int SEL_W  = $clog2(LANES),
  localparam int CTRL_W = LANES * SEL_W,
  localparam int NBYTES = VEC_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        op_sel,
  input logic [VEC_W-1:0]  vec_a,
  input logic [VEC_W-1:0]  vec_dst,
  input logic [SCL_W-1:0]  scl_in,
  input logic [CTRL_W-1:0] ctrl,
  input logic [VEC_W-1:0]  vec_res,
  input logic [SCL_W-1:0]  scl_res
);

  logic [1:0]        op_q;
  logic [VEC_W-1:0]  a_q, d_q;
  logic [SCL_W-1:0]  s_q;
  logic [CTRL_W-1:0] c_q;
  logic              v_q;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0; op_q <= '0; a_q <= '0; d_q <= '0; s_q <= '0; c_q <= '0;
      end else begin
        v_q <= 1'b1; op_q <= op_sel; a_q <= vec_a; d_q <= vec_dst;
        s_q <= scl_in; c_q <= ctrl;
      end
    end
  end else begin : g_now
    assign v_q = 1'b1;  assign op_q = op_sel; assign a_q = vec_a;
    assign d_q = vec_dst; assign s_q = scl_in; assign c_q = ctrl;
  end

  logic [LANES-1:0] lane_changed;
  logic [LANES-1:0] lane_eq_top;
  logic [SEL_W-1:0] sel_q;
  assign sel_q = c_q[SEL_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign lane_changed[g] = vec_res[g*LANE_W +: LANE_W] != d_q[g*LANE_W +: LANE_W];
    assign lane_eq_top[g]  = vec_res[g*LANE_W +: LANE_W] == a_q[VEC_W-1 -: LANE_W];
  end

  assert_idle_vec_zero_R1: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd0 || op_q == 2'd3) |-> vec_res == '0);

  assert_idle_scl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd1 || op_q == 2'd2) |-> scl_res == '0);

  assert_extract_zext_R2: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd0) |-> scl_res[SCL_W-1:LANE_W] == '0);

  assert_insert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd1) |-> (lane_changed & ~(LANES'(1) << sel_q)) == '0);

  assert_insert_value_R4: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd1) |-> vec_res[sel_q*LANE_W +: LANE_W] == s_q[LANE_W-1:0]);

  assert_broadcast_top_R6: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd2 && c_q == {CTRL_W{1'b1}}) |-> &lane_eq_top);

  assert_gather_upper_R7: assert property (@(posedge clk) disable iff (!rst_n || !v_q)
    (op_q == 2'd3) |-> scl_res[SCL_W-1:NBYTES] == '0);

endmodule

bind wpu_top wpu_top_chk #(
  .LANE_W(LANE_W), .LANES(LANES), .SCL_W(SCL_W), .OUT_REG(OUT_REG)
) u_wpu_top_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .vec_a(vec_a), .vec_dst(vec_dst),
  .scl_in(scl_in), .ctrl(ctrl), .vec_res(vec_res), .scl_res(scl_res)
);

// File: tb/wpu_top_bench.sv
module wpu_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [63:0] vec_a = '0, vec_dst = '0;
  logic [31:0] scl_in = '0;
  logic [7:0]  ctrl = '0;
  logic [63:0] vec_res;
  logic [31:0] scl_res;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wpu_top u_wpu_top (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .vec_a(vec_a), .vec_dst(vec_dst),
    .scl_in(scl_in), .ctrl(ctrl), .vec_res(vec_res), .scl_res(scl_res)
  );

  // Reference model, written with shifts rather than lane muxes.
  function automatic logic [95:0] model(input logic [1:0] op, input logic [63:0] a,
                                        input logic [63:0] d, input logic [31:0] s,
                                        input logic [7:0] c);
    logic [63:0] v;
    logic [31:0] r;
    logic [63:0] m;
    v = '0; r = '0;
    case (op)
      2'd0: r = {16'h0, 16'(a >> (16 * c[1:0]))};
      2'd1: begin
        m = 64'hFFFF << (16 * c[1:0]);
        v = (d & ~m) | ((64'(s[15:0]) << (16 * c[1:0])) & m);
      end
      2'd2: for (int i = 0; i < 4; i++)
              v = v | (64'(16'(a >> (16 * ((c >> (2 * i)) & 8'd3)))) << (16 * i));
      default: for (int k = 0; k < 8; k++) r = r | (32'((a >> (8 * k + 7)) & 64'd1) << k);
    endcase
    return {v, r};
  endfunction

  task automatic expect96(input string tag, input logic [95:0] exp);
    checks++;
    if ({vec_res, scl_res} !== exp) begin
      errors++;
      $display("FAIL %s: got vec=%h scl=%h expected vec=%h scl=%h",
               tag, vec_res, scl_res, exp[95:32], exp[31:0]);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic [63:0] a,
                     input logic [63:0] d, input logic [31:0] s, input logic [7:0] c);
    @(negedge clk);
    op_sel = op; vec_a = a; vec_dst = d; scl_in = s; ctrl = c;
    @(negedge clk);
    expect96(tag, model(op, a, d, s, c));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    logic [95:0] prev;
    void'($urandom(32'h5EED_0042));
    base = 64'hF00D_8C3A_7155_02E9;

    // R8: zero during reset even with active inputs
    op_sel = 2'd2; vec_a = base; ctrl = 8'hE4;
    repeat (3) @(negedge clk);
    expect96("R8 reset zero", 96'h0);
    rst_n = 1'b1;

    // R8: result only after the edge, then held
    run("R8 first result", 2'd0, base, '0, '0, 8'd2);
    prev = {vec_res, scl_res};
    @(negedge clk);
    op_sel = 2'd3; vec_a = ~base;
    #1 expect96("R8 hold before edge", prev);
    @(negedge clk);
    expect96("R8 next result", model(2'd3, ~base, '0, '0, 8'd0));

    // R2, R3: every extract position, with noise on ctrl[7:2]
    for (int p = 0; p < 4; p++) begin
      run("R2 extract", 2'd0, base, rnd64(), $urandom(), 8'(p));
      run("R3 extract upper ctrl ignored", 2'd0, base, rnd64(), $urandom(),
          {6'($urandom()), 2'(p)});
    end

    // R4, R3, R9: every insert position, noisy upper bits
    for (int p = 0; p < 4; p++) begin
      run("R4 insert", 2'd1, rnd64(), base, 32'h0000_A5C3, 8'(p));
      run("R3 insert upper ctrl ignored", 2'd1, rnd64(), base, 32'h0000_1E2F,
          {6'($urandom()), 2'(p)});
      run("R9 insert upper scalar ignored", 2'd1, rnd64(), base,
          {16'($urandom() | 32'h1), 16'h7B7B}, 8'(p));
    end

    // R5: all 256 shuffle controls on distinct words
    for (int c = 0; c < 256; c++)
      run("R5 shuffle", 2'd2, 64'h4444_3333_2222_1111, rnd64(), $urandom(), 8'(c));

    // R6: broadcasts
    run("R6 broadcast w0", 2'd2, base, '0, '0, 8'h00);
    run("R6 broadcast w1", 2'd2, base, '0, '0, 8'h55);
    run("R6 broadcast w2", 2'd2, base, '0, '0, 8'hAA);
    run("R6 broadcast w3", 2'd2, base, '0, '0, 8'hFF);

    // R7: sign gather corners and single-bit walks
    run("R7 gather all set", 2'd3, 64'h8080_8080_8080_8080, '0, '0, 8'h00);
    run("R7 gather none", 2'd3, 64'h7F7F_7F7F_7F7F_7F7F, '0, '0, 8'hFF);
    for (int k = 0; k < 8; k++)
      run("R7 gather one byte", 2'd3, 64'h1 << (8 * k + 7), rnd64(), $urandom(), 8'h00);

    // R1 plus mixed random traffic over all operations
    for (int n = 0; n < 400; n++)
      run("R1 random op", 2'($urandom()), rnd64(), rnd64(), $urandom(), 8'($urandom()));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule